// File: doc/BRIEF.md
# Prescaled Event Trigger

This block turns timer events into two requests: an interrupt request and a start-of-conversion (SOC) pulse for an analog converter. Each of the two channels has its own source selector. The selector picks one event from a four-bit event bus: counter-at-zero, counter-at-period, compare match A and compare match B. For the compare events, the selector also picks the counting direction in which a match counts. Each qualified event advances a small per-channel event counter. The channel issues its output on every first, second or third qualified event, as its prescale setting chooses.

Software can read both event counters. It can force either output at any time, and the force skips the prescaler. The interrupt channel keeps a sticky flag. While that flag is set, no new interrupt is issued, and it holds until software clears it with a strobe. The SOC channel has no flag and issues a one-clock pulse each time it fires. All outputs are registered, and reset is synchronous and active high.

Top module: `evtrig_top`

## Requirements
- R1: After reset, the interrupt flag, both pulses and both event counters are 0.
- R2: Selector code 1 takes counter-zero events, code 2 takes counter-period events, and code 3 takes either of them.
- R3: Selector codes 4 and 5 take compare-A matches only while the count direction input is 1 (code 4) or 0 (code 5). Codes 6 and 7 do the same for compare-B matches.
- R4: With prescale value N (1, 2 or 3), a channel fires on the Nth qualified event. Its pulse is high in the cycle after the clock edge that samples that event, and its counter returns to 0 at that edge.
- R5: The event counter increments on each qualified event that does not fire, and it saturates at 3.
- R6: A prescale value of 0 keeps the channel's counter at 0 and suppresses event-driven firing.
- R7: The interrupt flag sets when the interrupt fires, stays set until an interrupt-clear strobe is sampled, and blocks any interrupt firing while it is set. Qualified events that arrive during that time are still counted.
- R8: Each interrupt or SOC firing produces a pulse exactly one clock long.
- R9: A force strobe fires its channel at the next edge whatever the prescale setting and counter value, and it resets the counter. A forced interrupt is still blocked while the flag is set.
- R10: Selector code 0 takes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_zero | input | 1 | Counter reached zero |
| evt_prd | input | 1 | Counter reached period |
| evt_cmpa | input | 1 | Compare match A |
| evt_cmpb | input | 1 | Compare match B |
| cnt_up | input | 1 | Count direction, 1 = counting up |
| int_sel | input | 3 | Interrupt event selector |
| int_prd | input | 2 | Interrupt prescale (0 = off) |
| soc_sel | input | 3 | SOC event selector |
| soc_prd | input | 2 | SOC prescale (0 = off) |
| int_force | input | 1 | Software interrupt force strobe |
| soc_force | input | 1 | Software SOC force strobe |
| int_clr | input | 1 | Interrupt flag clear strobe |
| int_pulse | output | 1 | Interrupt request pulse |
| int_flag | output | 1 | Sticky interrupt flag |
| int_cnt | output | 2 | Interrupt event counter |
| soc_pulse | output | 1 | SOC pulse |
| soc_cnt | output | 2 | SOC event counter |

## Verification
The assertions check the rules that apply on every cycle. A counter moves only by one step up or back to 0, and a disabled channel's counter holds 0. The interrupt flag stays set until cleared, the flag rises only together with an interrupt pulse, and no interrupt pulse appears while the flag is set. Only the bench scenarios can show the rest. Those are the selector decoding with its direction qualification, the exact event on which each prescale value fires, saturation at 3, and forces overriding the prescaler.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE  = 3'd0,
    SEL_ZERO  = 3'd1,
    SEL_PRD   = 3'd2,
    SEL_ZP    = 3'd3,
    SEL_CA_UP = 3'd4,
    SEL_CA_DN = 3'd5,
    SEL_CB_UP = 3'd6,
    SEL_CB_DN = 3'd7
  } evt_sel_e;

  typedef struct packed {
    logic zero;
    logic prd;
    logic cmpa;
    logic cmpb;
  } evt_bus_t;
endpackage

// File: rtl/evtrig_qual.sv
module evtrig_qual
  import evtrig_pkg::*;
(
  input  evt_bus_t         evt_i,
  input  logic             cnt_up_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  always_comb begin
    unique case (evt_sel_e'(sel_i))
      SEL_ZERO:  hit_o = evt_i.zero;
      SEL_PRD:   hit_o = evt_i.prd;
      SEL_ZP:    hit_o = evt_i.zero | evt_i.prd;
      SEL_CA_UP: hit_o = evt_i.cmpa & cnt_up_i;
      SEL_CA_DN: hit_o = evt_i.cmpa & ~cnt_up_i;
      SEL_CB_UP: hit_o = evt_i.cmpb & cnt_up_i;
      SEL_CB_DN: hit_o = evt_i.cmpb & ~cnt_up_i;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/evtrig_prescale.sv
module evtrig_prescale #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             force_i,
  input  logic             block_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             evt_due;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    evt_due = hit_i && (prd_i != '0) && (cnt_inc >= prd_i);
    fire_o  = (evt_due | force_i) & ~block_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (prd_i == '0)   cnt_q <= '0;
    else if (fire_o)        cnt_q <= '0;
    else if (hit_i)         cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;

  // R6
  off_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (prd_i == '0) |=> (cnt_q == '0));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |-> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/evtrig_top.sv
module evtrig_top
  import evtrig_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter int N_CH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic             evt_cmpa,
  input  logic             evt_cmpb,
  input  logic             cnt_up,
  input  logic [SEL_W-1:0] int_sel,
  input  logic [CNT_W-1:0] int_prd,
  input  logic [SEL_W-1:0] soc_sel,
  input  logic [CNT_W-1:0] soc_prd,
  input  logic             int_force,
  input  logic             soc_force,
  input  logic             int_clr,
  output logic             int_pulse,
  output logic             int_flag,
  output logic [CNT_W-1:0] int_cnt,
  output logic             soc_pulse,
  output logic [CNT_W-1:0] soc_cnt
);
  localparam int CH_INT = 0;
  localparam int CH_SOC = 1;

  evt_bus_t         evt;
  logic [SEL_W-1:0] sel_a   [N_CH];
  logic [CNT_W-1:0] prd_a   [N_CH];
  logic [CNT_W-1:0] cnt_a   [N_CH];
  logic [N_CH-1:0]  frc_a;
  logic [N_CH-1:0]  blk_a;
  logic [N_CH-1:0]  hit_a;
  logic [N_CH-1:0]  fire_a;
  logic [N_CH-1:0]  pulse_q;
  logic             flag_q;

  assign evt.zero = evt_zero;
  assign evt.prd  = evt_prd;
  assign evt.cmpa = evt_cmpa;
  assign evt.cmpb = evt_cmpb;

  assign sel_a[CH_INT] = int_sel;
  assign sel_a[CH_SOC] = soc_sel;
  assign prd_a[CH_INT] = int_prd;
  assign prd_a[CH_SOC] = soc_prd;
  assign frc_a[CH_INT] = int_force;
  assign frc_a[CH_SOC] = soc_force;
  assign blk_a[CH_INT] = flag_q;
  assign blk_a[CH_SOC] = 1'b0;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    evtrig_qual i_qual (
      .evt_i    (evt),
      .cnt_up_i (cnt_up),
      .sel_i    (sel_a[ch]),
      .hit_o    (hit_a[ch])
    );

    evtrig_prescale #(.CNT_W(CNT_W)) i_pre (
      .clk     (clk),
      .rst     (rst),
      .hit_i   (hit_a[ch]),
      .force_i (frc_a[ch]),
      .block_i (blk_a[ch]),
      .prd_i   (prd_a[ch]),
      .fire_o  (fire_a[ch]),
      .cnt_o   (cnt_a[ch])
    );

    always_ff @(posedge clk) begin
      if (rst) pulse_q[ch] <= 1'b0;
      else     pulse_q[ch] <= fire_a[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 flag_q <= 1'b0;
    else if (fire_a[CH_INT]) flag_q <= 1'b1;
    else if (int_clr)        flag_q <= 1'b0;
  end

  assign int_pulse = pulse_q[CH_INT];
  assign soc_pulse = pulse_q[CH_SOC];
  assign int_flag  = flag_q;
  assign int_cnt   = cnt_a[CH_INT];
  assign soc_cnt   = cnt_a[CH_SOC];

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !int_clr) |=> flag_q);

  // R7
  flag_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> !int_pulse);

  // R8
  int_single_chk: assert property (@(posedge clk) disable iff (rst)
    int_pulse |=> !int_pulse);

  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> int_pulse);
endmodule

// File: tb/test_evtrig_top.sv
module test_evtrig_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_zero = 0, evt_prd = 0, evt_cmpa = 0, evt_cmpb = 0;
  logic       cnt_up = 1'b1;
  logic [2:0] int_sel = 0, soc_sel = 0;
  logic [1:0] int_prd = 0, soc_prd = 0;
  logic       int_force = 0, soc_force = 0, int_clr = 0;
  logic       int_pulse, int_flag, soc_pulse;
  logic [1:0] int_cnt, soc_cnt;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  evtrig_top i_evtrig_top (
    .clk(clk), .rst(rst),
    .evt_zero(evt_zero), .evt_prd(evt_prd), .evt_cmpa(evt_cmpa), .evt_cmpb(evt_cmpb),
    .cnt_up(cnt_up),
    .int_sel(int_sel), .int_prd(int_prd), .soc_sel(soc_sel), .soc_prd(soc_prd),
    .int_force(int_force), .soc_force(soc_force), .int_clr(int_clr),
    .int_pulse(int_pulse), .int_flag(int_flag), .int_cnt(int_cnt),
    .soc_pulse(soc_pulse), .soc_cnt(soc_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: events {zero,prd,cmpa,cmpb}, strobes {int_force,soc_force,int_clr}
  task automatic cyc(input logic [3:0] ev, input logic [2:0] st);
    @(negedge clk);
    {evt_zero, evt_prd, evt_cmpa, evt_cmpb} = ev;
    {int_force, soc_force, int_clr} = st;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 int_flag", int_flag, 0);
    chk("R1 int_pulse", int_pulse, 0);
    chk("R1 soc_pulse", soc_pulse, 0);
    chk("R1 int_cnt", int_cnt, 0);
    chk("R1 soc_cnt", soc_cnt, 0);
  endtask

  task automatic t_soc_prescale;
    soc_sel = 3'd1; soc_prd = 2'd3;
    cyc(4'b1000, 3'b000); chk("R4 n3 e1 pulse", soc_pulse, 0); chk("R5 cnt1", soc_cnt, 1);
    cyc(4'b1000, 3'b000); chk("R4 n3 e2 pulse", soc_pulse, 0); chk("R5 cnt2", soc_cnt, 2);
    cyc(4'b1000, 3'b000); chk("R4 n3 e3 pulse", soc_pulse, 1); chk("R4 cnt reset", soc_cnt, 0);
    cyc(4'b0000, 3'b000); chk("R8 soc one clock", soc_pulse, 0);
    soc_prd = 2'd2;
    cyc(4'b1000, 3'b000); chk("R4 n2 e1", soc_pulse, 0);
    cyc(4'b1000, 3'b000); chk("R4 n2 e2", soc_pulse, 1);
    soc_prd = 2'd1;
    cyc(4'b1000, 3'b000); chk("R4 n1 a", soc_pulse, 1);
    cyc(4'b1000, 3'b000); chk("R4 n1 b", soc_pulse, 1);
    cyc(4'b0000, 3'b000);
  endtask

  task automatic t_select;
    soc_prd = 2'd1; soc_sel = 3'd2;
    cyc(4'b1000, 3'b000); chk("R2 prd sel ignores zero", soc_pulse, 0);
    cyc(4'b0100, 3'b000); chk("R2 prd sel takes prd", soc_pulse, 1);
    soc_sel = 3'd3;
    cyc(4'b1000, 3'b000); chk("R2 either zero", soc_pulse, 1);
    cyc(4'b0100, 3'b000); chk("R2 either prd", soc_pulse, 1);
    soc_sel = 3'd0;
    cyc(4'b1111, 3'b000); chk("R10 none pulse", soc_pulse, 0);
    chk("R10 none cnt", soc_cnt, 0);
    cyc(4'b0000, 3'b000);
  endtask

  task automatic t_direction;
    soc_prd = 2'd1; soc_sel = 3'd4;
    cnt_up = 1'b0; cyc(4'b0010, 3'b000); chk("R3 cmpa up sel, down", soc_pulse, 0);
    cnt_up = 1'b1; cyc(4'b0010, 3'b000); chk("R3 cmpa up sel, up", soc_pulse, 1);
    soc_sel = 3'd7;
    cnt_up = 1'b1; cyc(4'b0001, 3'b000); chk("R3 cmpb dn sel, up", soc_pulse, 0);
    cnt_up = 1'b0; cyc(4'b0001, 3'b000); chk("R3 cmpb dn sel, down", soc_pulse, 1);
    soc_sel = 3'd5;
    cyc(4'b0001, 3'b000); chk("R3 cmpa dn ignores cmpb", soc_pulse, 0);
    cnt_up = 1'b1;
    cyc(4'b0000, 3'b000);
  endtask

  task automatic t_disable_force;
    soc_sel = 3'd1; soc_prd = 2'd0;
    cyc(4'b1000, 3'b000); chk("R6 off pulse", soc_pulse, 0); chk("R6 off cnt", soc_cnt, 0);
    cyc(4'b1000, 3'b000); chk("R6 off cnt again", soc_cnt, 0);
    cyc(4'b0000, 3'b010); chk("R9 force while off", soc_pulse, 1);
    soc_prd = 2'd3;
    cyc(4'b1000, 3'b000); cyc(4'b1000, 3'b000); chk("R5 cnt2 pre force", soc_cnt, 2);
    cyc(4'b0000, 3'b010); chk("R9 force pulse", soc_pulse, 1); chk("R9 force resets cnt", soc_cnt, 0);
    cyc(4'b0000, 3'b000); chk("R8 force one clock", soc_pulse, 0);
  endtask

  task automatic t_interrupt;
    int_sel = 3'd1; int_prd = 2'd1;
    cyc(4'b1000, 3'b000); chk("R4 int fires", int_pulse, 1); chk("R7 flag set", int_flag, 1);
    cyc(4'b1000, 3'b000); chk("R7 blocked", int_pulse, 0); chk("R5 cnt1", int_cnt, 1);
    cyc(4'b1000, 3'b000); chk("R5 cnt2", int_cnt, 2);
    cyc(4'b1000, 3'b000); chk("R5 cnt3", int_cnt, 3);
    cyc(4'b1000, 3'b000); chk("R5 saturate", int_cnt, 3); chk("R7 still blocked", int_pulse, 0);
    cyc(4'b0000, 3'b100); chk("R9 force blocked", int_pulse, 0); chk("R7 flag held", int_flag, 1);
    cyc(4'b0000, 3'b001); chk("R7 flag cleared", int_flag, 0); chk("R7 cnt kept", int_cnt, 3);
    cyc(4'b1000, 3'b000); chk("R7 fires after clear", int_pulse, 1); chk("R4 int cnt reset", int_cnt, 0);
    cyc(4'b0000, 3'b001); chk("R8 int one clock", int_pulse, 0);
    cyc(4'b0000, 3'b100); chk("R9 int force", int_pulse, 1); chk("R9 int flag", int_flag, 1);
    cyc(4'b0000, 3'b001);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_soc_prescale();
    t_select();
    t_direction();
    t_disable_force();
    t_interrupt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule